// File: doc/BRIEF.md
# Hierarchical Table-Walk Permission Accumulator

This block follows one multi-level page-table walk and keeps the access restrictions that table-level descriptors pass down to the levels below them. A walk begins with a one-cycle `start` pulse. The pulse carries the translation regime, the address half, the control bits for that regime and the input virtual address. The block checks that the address lies inside the configured range. It also picks the effective hierarchical-permission-disable flag for the regime and half. When that flag is set, the permission bits in table descriptors become neutral, so a walk inherits no restriction from the upper levels.

After a start that does not fault, each descriptor arrives as a one-cycle `desc_valid` strobe. Table descriptors fold their permission bits into the running flags. A leaf descriptor (block or page) ends the walk, and `done` pulses with the final flags. A start that faults ends the walk at once: `done` pulses with `fault` set. A constant capability word reports that the disable feature is present. Descriptor fetch, address generation and TLB fill are handled by other logic.

Top module: `walk_perm_accum`

## Requirements
- R1: The effective disable flag `hpd_eff` is latched at start. The regime encodings are 0 = lowest privileged, 1 = hypervisor, 2 = highest and 3 = reserved. Regime 0 uses `dis0` for the lower half (`upper`=0) and `dis1` for the upper half. Regime 1 uses `dis1` for the upper half; for the lower half it uses `dis0` when `host_ext`=1 and `dis_single` otherwise. Regime 2 uses `dis_single` for both halves. Regime 3 gives 0.
- R2: Let the high-bit mask hold every `vaddr` bit whose index is at least `tsz`; the mask is empty when `tsz` >= VA_W. A lower-half walk is out of range if any masked bit is 1. An upper-half walk is out of range if any masked bit is 0.
- R3: A start also faults in each of these cases: the walk-off bit for its half is set (`walk_off0` for the lower half, `walk_off1` for the upper half); regime 1, upper half, with `host_ext`=0; regime 2, upper half; or regime 3.
- R4: On a faulting start, `done`=1 and `fault`=1 one cycle later, `busy` stays 0, and descriptors that arrive before the next start are ignored.
- R5: On a non-faulting start, the flags are set one cycle later to `rw_ok`=1, `user_ok`=1, `xn`=0, `pxn`=0, `secure`=`secure_in`, with `busy`=1, `fault`=0 and `done`=0.
- R6: A table descriptor (`desc_is_table`=1) sets `rw_ok` to `rw_ok` & (`d_rw` | `hpd_eff`) and sets `user_ok` to `user_ok` & (`d_user` | `hpd_eff`).
- R7: A table descriptor sets `xn` to `xn` | (`d_xn` & ~`hpd_eff`) and sets `pxn` to `pxn` | (`d_pxn` & ~`hpd_eff`).
- R8: A table descriptor sets `secure` to `secure` & `d_secure`, whatever the value of `hpd_eff`.
- R9: A leaf descriptor (`desc_is_table`=0) during a walk makes `done` pulse for one cycle on the next cycle, clears `busy` and leaves every flag unchanged. Descriptors are ignored while `busy`=0.
- R10: `feat_id` always reads 16'h1000 (capability field [15:12] = 1).
- R11: After reset: `busy`=0, `done`=0, `fault`=0, `rw_ok`=1, `user_ok`=1, `xn`=0, `pxn`=0, `secure`=0, `hpd_eff`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Walk-start pulse |
| regime | input | 2 | Translation regime (0 lowest, 1 hypervisor, 2 highest, 3 reserved) |
| upper | input | 1 | Address half: 1 = upper |
| host_ext | input | 1 | Host-extension mode of the hypervisor regime |
| dis0 | input | 1 | Disable bit for the lower half |
| dis1 | input | 1 | Disable bit for the upper half |
| dis_single | input | 1 | Single disable bit of regimes with one range |
| walk_off0 | input | 1 | Walks in the lower half are disabled |
| walk_off1 | input | 1 | Walks in the upper half are disabled |
| tsz | input | $clog2(VA_W+1) | Index of the lowest bit above the translated range |
| vaddr | input | VA_W | Input virtual address |
| secure_in | input | 1 | Initial secure-lookup flag |
| desc_valid | input | 1 | Descriptor strobe |
| desc_is_table | input | 1 | 1 = table descriptor, 0 = leaf |
| d_rw | input | 1 | Table bit: writes allowed below |
| d_user | input | 1 | Table bit: user access allowed below |
| d_xn | input | 1 | Table bit: execute-never below |
| d_pxn | input | 1 | Table bit: privileged execute-never below |
| d_secure | input | 1 | Table bit: secure lookup below |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 1 | Range fault of the last walk |
| rw_ok | output | 1 | Accumulated write permission |
| user_ok | output | 1 | Accumulated user permission |
| xn | output | 1 | Accumulated execute-never |
| pxn | output | 1 | Accumulated privileged execute-never |
| secure | output | 1 | Accumulated secure-lookup flag |
| hpd_eff | output | 1 | Effective disable flag of the current walk |
| feat_id | output | 16 | Constant capability word |

## Verification
The hardest case to reach from the ports is the one where the disable flag changes what a walk accumulates. It needs a start whose regime, half and host-extension setting route a set disable bit to `hpd_eff`, followed by table descriptors whose restrictive bits would otherwise stick. The bench first sweeps every combination of the selection inputs, so the hypervisor lower half with host extension on and off is covered. It then runs every pair of two table descriptors under both disable values, which shows that set bits are neutralised while the secure bit still narrows. A separate sweep over `tsz` and edge addresses in both halves exercises the range fault.

// File: rtl/walk_perm_accum.sv
module walk_perm_accum #(
  parameter int VA_W = 16,
  localparam int TSZ_W = $clog2(VA_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       regime,
  input  logic             upper,
  input  logic             host_ext,
  input  logic             dis0,
  input  logic             dis1,
  input  logic             dis_single,
  input  logic             walk_off0,
  input  logic             walk_off1,
  input  logic [TSZ_W-1:0] tsz,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             secure_in,
  input  logic             desc_valid,
  input  logic             desc_is_table,
  input  logic             d_rw,
  input  logic             d_user,
  input  logic             d_xn,
  input  logic             d_pxn,
  input  logic             d_secure,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic             rw_ok,
  output logic             user_ok,
  output logic             xn,
  output logic             pxn,
  output logic             secure,
  output logic             hpd_eff,
  output logic [15:0]      feat_id
);

  localparam logic [1:0] RG_LOW = 2'd0;
  localparam logic [1:0] RG_HYP = 2'd1;
  localparam logic [1:0] RG_TOP = 2'd2;

  logic [VA_W-1:0] hi_mask;
  logic            range_bad;
  logic            hpd_sel;
  logic            fault_sel;

  always_comb begin
    for (int i = 0; i < VA_W; i++)
      hi_mask[i] = (i >= int'(tsz));
  end

  assign range_bad = upper ? ((vaddr & hi_mask) != hi_mask)
                           : ((vaddr & hi_mask) != '0);

  always_comb begin
    case (regime)
      RG_LOW:  hpd_sel = upper ? dis1 : dis0;
      RG_HYP:  hpd_sel = upper ? dis1 : (host_ext ? dis0 : dis_single);
      RG_TOP:  hpd_sel = dis_single;
      default: hpd_sel = 1'b0;
    endcase
  end

  assign fault_sel = range_bad
                   | (upper ? walk_off1 : walk_off0)
                   | (regime == RG_HYP && upper && !host_ext)
                   | (regime == RG_TOP && upper)
                   | (regime == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      fault   <= 1'b0;
      rw_ok   <= 1'b1;
      user_ok <= 1'b1;
      xn      <= 1'b0;
      pxn     <= 1'b0;
      secure  <= 1'b0;
      hpd_eff <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        hpd_eff <= hpd_sel;
        fault   <= fault_sel;
        busy    <= !fault_sel;
        done    <= fault_sel;
        rw_ok   <= 1'b1;
        user_ok <= 1'b1;
        xn      <= 1'b0;
        pxn     <= 1'b0;
        secure  <= secure_in;
      end else if (busy && desc_valid) begin
        if (desc_is_table) begin
          rw_ok   <= rw_ok   & (d_rw   | hpd_eff);
          user_ok <= user_ok & (d_user | hpd_eff);
          xn      <= xn      | (d_xn   & ~hpd_eff);
          pxn     <= pxn     | (d_pxn  & ~hpd_eff);
          secure  <= secure  & d_secure;
        end else begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign feat_id = 16'h1000;

endmodule

// File: rtl/walk_perm_accum_chk.sv
module walk_perm_accum_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic desc_valid,
  input logic desc_is_table,
  input logic busy,
  input logic done,
  input logic fault,
  input logic rw_ok,
  input logic user_ok,
  input logic xn,
  input logic pxn,
  input logic secure,
  input logic hpd_eff
);

  p_fault_ends_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> !busy);

  p_start_permissive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rw_ok && user_ok && !xn && !pxn));

  p_rw_never_regained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!rw_ok || $past(rw_ok)) && (!user_ok || $past(user_ok)));

  p_xn_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (xn || !$past(xn)) && (pxn || !$past(pxn)));

  p_hpd_neutral_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && desc_valid && desc_is_table && hpd_eff && !start)
      |=> $stable(rw_ok) && $stable(user_ok) && $stable(xn) && $stable(pxn));

  p_secure_narrows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> (!secure || $past(secure)));

  p_leaf_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && desc_valid && !desc_is_table && !start)
      |=> done && !busy && $stable(rw_ok) && $stable(xn) && $stable(secure));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);

endmodule

bind walk_perm_accum walk_perm_accum_chk chk_i (.*);

// File: tb/walk_perm_accum_test.sv
module walk_perm_accum_test;
  localparam int VA_W = 16;
  localparam int TSZ_W = $clog2(VA_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] regime = '0;
  logic upper = 1'b0, host_ext = 1'b0, dis0 = 1'b0, dis1 = 1'b0, dis_single = 1'b0;
  logic walk_off0 = 1'b0, walk_off1 = 1'b0;
  logic [TSZ_W-1:0] tsz = '0;
  logic [VA_W-1:0] vaddr = '0;
  logic secure_in = 1'b0;
  logic desc_valid = 1'b0, desc_is_table = 1'b0;
  logic d_rw = 1'b0, d_user = 1'b0, d_xn = 1'b0, d_pxn = 1'b0, d_secure = 1'b0;
  logic busy, done, fault, rw_ok, user_ok, xn, pxn, secure, hpd_eff;
  logic [15:0] feat_id;

  int n_chk = 0;
  int n_bad = 0;

  walk_perm_accum #(.VA_W(VA_W)) uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [1:0] r, input logic u, input logic he,
                          input logic [2:0] dis, input logic [1:0] wo,
                          input int t, input logic [VA_W-1:0] va, input logic s);
    start = 1'b1; regime = r; upper = u; host_ext = he;
    {dis_single, dis1, dis0} = dis; {walk_off1, walk_off0} = wo;
    tsz = TSZ_W'(t); vaddr = va; secure_in = s;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic send_desc(input logic tbl, input logic [4:0] b);
    desc_valid = 1'b1; desc_is_table = tbl;
    {d_rw, d_user, d_xn, d_pxn, d_secure} = b;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  function automatic logic exp_hpd(input logic [1:0] r, input logic u, input logic he,
                                   input logic [2:0] dis);
    if (r == 2'd0) return u ? dis[1] : dis[0];
    if (r == 2'd1) return u ? dis[1] : (he ? dis[0] : dis[2]);
    if (r == 2'd2) return dis[2];
    return 1'b0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state, R10 capability word
    chk("R11 reset", {busy, done, fault, rw_ok, user_ok, xn, pxn, secure, hpd_eff},
        9'b000110000);
    chk("R10 feat_id", feat_id, 16'h1000);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 descriptor while idle is ignored
    send_desc(1'b1, 5'b00110);
    chk("R9 idle desc ignored", {done, rw_ok, user_ok, xn, pxn}, 5'b01100);

    // R1, R3, R4, R5: sweep of selection and fault controls
    for (int r = 0; r < 4; r++)
      for (int u = 0; u < 2; u++)
        for (int he = 0; he < 2; he++)
          for (int d = 0; d < 8; d++)
            for (int w = 0; w < 4; w++) begin
              logic ef;
              ef = (u ? w[1] : w[0]) || (r == 1 && u == 1 && he == 0) ||
                   (r == 2 && u == 1) || (r == 3);
              do_start(2'(r), 1'(u), 1'(he), 3'(d), 2'(w), VA_W, '0, 1'b1);
              chk("R1 hpd select", hpd_eff, exp_hpd(2'(r), 1'(u), 1'(he), 3'(d)));
              chk("R3 fault", fault, ef);
              chk("R4 done/busy", {done, busy}, {ef, !ef});
              if (!ef) begin
                chk("R5 permissive", {rw_ok, user_ok, xn, pxn, secure}, 5'b11001);
                send_desc(1'b0, 5'b0);
                chk("R9 leaf done", {done, busy}, 2'b10);
              end else begin
                send_desc(1'b0, 5'b0);
                chk("R4 desc after fault ignored", {done, busy, fault}, 3'b001);
              end
            end

    // R2 range sweep
    for (int t = 0; t <= VA_W + 1; t++)
      for (int u = 0; u < 2; u++)
        for (int k = 0; k < 8; k++) begin
          logic [VA_W-1:0] hm, va;
          logic bad;
          case (k)
            0: va = 16'h0000; 1: va = 16'hffff; 2: va = 16'h8000; 3: va = 16'h7fff;
            4: va = 16'h00ff; 5: va = 16'hff00; 6: va = 16'h0001; default: va = 16'hfffe;
          endcase
          hm = (t >= VA_W) ? '0 : (16'hffff << t);
          bad = u ? ((va & hm) != hm) : ((va & hm) != 0);
          do_start(2'd0, 1'(u), 1'b0, 3'b000, 2'b00, t, va, 1'b0);
          chk("R2 range fault", {fault, done}, {bad, bad});
          if (!bad) send_desc(1'b0, 5'b0);
        end

    // R6, R7, R8: every pair of table descriptors under both disable values
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < 32; a++)
        for (int b = 0; b < 32; b++) begin
          logic [4:0] da, db;
          logic erw, eus, exn, epx, esc;
          da = 5'(a); db = 5'(b);
          erw = (da[4] | h[0]) & (db[4] | h[0]);
          eus = (da[3] | h[0]) & (db[3] | h[0]);
          exn = (da[2] & ~h[0]) | (db[2] & ~h[0]);
          epx = (da[1] & ~h[0]) | (db[1] & ~h[0]);
          esc = da[0] & db[0];
          do_start(2'd2, 1'b0, 1'b0, {h[0], 2'b00}, 2'b00, VA_W, '0, 1'b1);
          send_desc(1'b1, da);
          send_desc(1'b1, db);
          chk("R6 rw/user", {rw_ok, user_ok}, {erw, eus});
          chk("R7 xn/pxn", {xn, pxn}, {exn, epx});
          chk("R8 secure", secure, esc);
          send_desc(1'b0, 5'b00000);
          chk("R9 leaf keeps flags", {done, busy, rw_ok, user_ok, xn, pxn, secure},
              {2'b10, erw, eus, exn, epx, esc});
          send_desc(1'b1, 5'b00110);
          chk("R9 after leaf ignored", {done, rw_ok, xn, secure}, {1'b0, erw, exn, esc});
        end

    chk("R10 feat_id end", feat_id, 16'h1000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule